// File: doc/BRIEF.md
# Programmable Trigger Lookup Table

This block reduces a vector of physical trigger bits to one trigger decision. The decision for every possible trigger pattern is held in a truth table that software loads through a simple register port. The table is stored as 16-bit words, and the number of words follows from the number of trigger inputs. The full trigger vector is used as the bit address into the table. Its upper bits pick a word, and its four lowest bits pick a bit inside that word. The picked bit is registered and driven out as the decision.

With the default eight inputs, five bits carry individual detector triggers, one bit carries the combined calorimeter trigger and two bits carry laser triggers. The table then holds sixteen words, which covers all 256 patterns. The port also has a read-only register that reports the input count, so software can size the table without knowing the build.

Top module: `trig_lut_top`

## Requirements
- R1: After a synchronous active-low reset, every table word is zero, `trig_out` is 0 and `reg_rdata` is 0, so no pattern fires until the table is loaded.
- R2: A write with `reg_we` high to address 0x100+k, where k is less than the word count, stores `reg_wdata` in word k. A later read of that address returns it.
- R3: `trig_out` after clock edge t equals bit `trig_vec[3:0]` of word `trig_vec[N-1:4]`, sampled at edge t, with a latency of one clock.
- R4: The word count is 1 when N is 4 or less, and 2^(N-4) otherwise. Writes to window addresses at or above 0x100 plus the word count leave every word unchanged.
- R5: Reads of window addresses beyond the word count, and of any address that is neither a table word nor the count register, return 0.
- R6: A read of address 0x00F returns the number of trigger inputs N, zero-extended to 16 bits.
- R7: When a lookup and a write to the same word occur at the same edge, the lookup uses the previous contents, and the next lookup uses the new contents.
- R8: `reg_rdata` is registered: it shows the data for the address that was present at the previous clock edge.
- R9: When N is less than 4, the missing upper bit-select bits are taken as zero, so only bits 0 to 2^N-1 of word 0 are reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_vec | input | N_TRIG | Physical trigger bits, used as the table bit address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register address: table window 0x100 to 0x1FF, count register at 0x00F |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| trig_out | output | 1 | Registered trigger decision |

## Verification
With eight inputs, the bench loads several tables: a checkerboard-like fixed pattern and random words. It sweeps all 256 trigger patterns against each table. This separates errors in the word select from errors in the bit select, since each pattern is unique in both its word and its bit. Writes just past the valid word count, and reads of unmapped addresses, show whether the decode limit is exact. A lookup timed on the same edge as a write to its own word shows whether the old or the new contents are used. A second instance with three inputs is swept over its eight patterns to confirm the zero-extension of the bit select.

// File: rtl/trig_lut_pkg.sv
// Package: shared constants and sizing helpers for the trigger lookup table.
// Assumes a 9-bit register address with the table window in its upper half.
package trig_lut_pkg;

    localparam int REG_AW   = 9;
    localparam int REG_DW   = 16;
    localparam logic [REG_AW-1:0] CNT_ADDR = 9'h00F;

    // Number of 16-bit table words needed for n trigger inputs.
    function automatic int lut_words(input int n);
        return (n <= 4) ? 1 : (1 << (n - 4));
    endfunction

    // Width of the bit index into the flattened table (at least four bits).
    function automatic int lut_idx_w(input int n);
        return (n < 4) ? 4 : n;
    endfunction

endpackage

// File: rtl/trig_lut_bank.sv
// Module: table word storage with write decode.
// Holds WORDS registers of REG_DW bits. A write lands only when the address
// is inside the window and its offset names an existing word; any other write
// is dropped. Assumes WORDS is at most 256.
module trig_lut_bank #(
    parameter int WORDS = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [trig_lut_pkg::REG_AW-1:0]     addr,
    input  logic [trig_lut_pkg::REG_DW-1:0]     wdata,
    output logic [trig_lut_pkg::REG_DW-1:0]     words [WORDS],
    output logic [WORDS*trig_lut_pkg::REG_DW-1:0] flat
);
    import trig_lut_pkg::*;

    logic       in_window;
    logic [7:0] offset;

    // Purpose: split the address into the window flag and the word offset.
    always_comb begin
        in_window = addr[REG_AW-1];
        offset    = addr[7:0];
    end

    genvar w;
    generate
        for (w = 0; w < WORDS; w++) begin : g_word
            logic hit;

            // Purpose: decode a write aimed at this word.
            always_comb hit = we && in_window && (offset == 8'(w));

            // Purpose: hold one table word, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    words[w] <= '0;
                end else if (hit) begin
                    words[w] <= wdata;
                end
            end

            assign flat[w*REG_DW +: REG_DW] = words[w];
        end
    endgenerate

endmodule

// File: rtl/trig_lut_pick.sv
// Module: registered bit select from the flattened table.
// The trigger vector, zero-extended to IDX_W bits, is the bit address. This
// is equivalent to word = upper bits and bit = lowest four bits. Assumes
// the flat vector width is exactly 2**IDX_W.
module trig_lut_pick #(
    parameter int N_TRIG = 8,
    parameter int IDX_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_TRIG-1:0]       trig_vec,
    input  logic [(1<<IDX_W)-1:0]   flat,
    output logic                    trig_out
);
    logic [IDX_W-1:0] idx;

    // Purpose: widen the trigger vector to a full bit index (missing bits zero).
    always_comb idx = IDX_W'(trig_vec);

    // Purpose: register the selected table bit as the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_out <= 1'b0;
        end else begin
            trig_out <= flat[idx];
        end
    end

endmodule

// File: rtl/trig_lut_readback.sv
// Module: registered read mux for the register port.
// Returns the input count at the count address, a table word inside the
// valid range, and zero for everything else.
module trig_lut_readback #(
    parameter int N_TRIG = 8,
    parameter int WORDS  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [trig_lut_pkg::REG_AW-1:0] addr,
    input  logic [trig_lut_pkg::REG_DW-1:0] words [WORDS],
    output logic [trig_lut_pkg::REG_DW-1:0] rdata
);
    import trig_lut_pkg::*;

    logic [REG_DW-1:0] rd_next;

    // Purpose: pick the read value for the present address.
    always_comb begin
        rd_next = '0;
        if (addr == CNT_ADDR) begin
            rd_next = REG_DW'(N_TRIG);
        end else if (addr[REG_AW-1]) begin
            for (int w = 0; w < WORDS; w++) begin
                if (addr[7:0] == 8'(w)) begin
                    rd_next = words[w];
                end
            end
        end
    end

    // Purpose: register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/trig_lut_top.sv
// Module: programmable trigger lookup table, top level.
// Maps N_TRIG trigger bits to one registered decision through a truth table
// that is loaded over a 16-bit register port. Assumes N_TRIG is 1 to 12, so
// that the table fits in the 256-word window.
module trig_lut_top #(
    parameter int N_TRIG = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_TRIG-1:0]               trig_vec,
    input  logic                            reg_we,
    input  logic [trig_lut_pkg::REG_AW-1:0] reg_addr,
    input  logic [trig_lut_pkg::REG_DW-1:0] reg_wdata,
    output logic [trig_lut_pkg::REG_DW-1:0] reg_rdata,
    output logic                            trig_out
);
    import trig_lut_pkg::*;

    localparam int WORDS  = lut_words(N_TRIG);
    localparam int IDX_W  = lut_idx_w(N_TRIG);
    localparam int FLAT_W = WORDS * REG_DW;

    logic [REG_DW-1:0] tbl_words [WORDS];
    logic [FLAT_W-1:0] tbl_flat;

    trig_lut_bank #(.WORDS(WORDS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .words (tbl_words),
        .flat  (tbl_flat)
    );

    trig_lut_pick #(.N_TRIG(N_TRIG), .IDX_W(IDX_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_vec (trig_vec),
        .flat     (tbl_flat),
        .trig_out (trig_out)
    );

    trig_lut_readback #(.N_TRIG(N_TRIG), .WORDS(WORDS)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .words (tbl_words),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/trig_lut_chk.sv
// Module: assertion checker for the trigger lookup table, bound to the top.
// Observes the ports and the flattened table that the storage drives.
module trig_lut_chk #(
    parameter int N_TRIG = 8,
    parameter int WORDS  = 16,
    parameter int IDX_W  = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [N_TRIG-1:0]               trig_vec,
    input logic                            reg_we,
    input logic [trig_lut_pkg::REG_AW-1:0] reg_addr,
    input logic [trig_lut_pkg::REG_DW-1:0] reg_wdata,
    input logic [trig_lut_pkg::REG_DW-1:0] reg_rdata,
    input logic                            trig_out,
    input logic [WORDS*16-1:0]             tbl_flat
);
    import trig_lut_pkg::*;

    logic             win_ok;
    logic             unmapped;
    logic [IDX_W-1:0] bit_idx;
    logic             table_bit;

    // Purpose: classify the address and look up the table bit for the ports.
    always_comb begin
        win_ok    = reg_addr[REG_AW-1] && (int'(reg_addr[7:0]) < WORDS);
        unmapped  = !win_ok && (reg_addr != CNT_ADDR);
        bit_idx   = IDX_W'(trig_vec);
        table_bit = tbl_flat[bit_idx];
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0 && trig_out == 1'b0 && tbl_flat == '0));

    a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && win_ok) |=>
            tbl_flat[int'($past(reg_addr[7:0]))*16 +: 16] == $past(reg_wdata));

    a_r3_lookup_bit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> trig_out == $past(table_bit));

    a_r4_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !win_ok) |=> $stable(tbl_flat));

    a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |=> reg_rdata == '0);

    a_r6_count_value: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CNT_ADDR) |=> reg_rdata == 16'(N_TRIG));

endmodule

bind trig_lut_top trig_lut_chk #(
    .N_TRIG (N_TRIG),
    .WORDS  (WORDS),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_vec  (trig_vec),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .trig_out  (trig_out),
    .tbl_flat  (tbl_flat)
);

// File: tb/sim_trig_lut_top.sv
// Bench: u0 uses eight inputs (sixteen words); u1 uses three inputs (one word).
module sim_trig_lut_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [7:0]  trig0 = '0;
    logic        we0 = 1'b0;
    logic [8:0]  addr0 = '0;
    logic [15:0] wd0 = '0;
    logic [15:0] rdata0;
    logic        tout0;

    logic [2:0]  trig1 = '0;
    logic        we1 = 1'b0;
    logic [8:0]  addr1 = '0;
    logic [15:0] wd1 = '0;
    logic [15:0] rdata1;
    logic        tout1;

    trig_lut_top #(.N_TRIG(8)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_vec(trig0), .reg_we(we0),
        .reg_addr(addr0), .reg_wdata(wd0), .reg_rdata(rdata0), .trig_out(tout0)
    );

    trig_lut_top #(.N_TRIG(3)) u1 (
        .clk(clk), .rst_n(rst_n), .trig_vec(trig1), .reg_we(we1),
        .reg_addr(addr1), .reg_wdata(wd1), .reg_rdata(rdata1), .trig_out(tout1)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cycles = 0;
    logic [15:0] ref_tbl [16];

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr0(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk); we0 = 1'b1; addr0 = a; wd0 = d;
        @(negedge clk); we0 = 1'b0;
    endtask

    task automatic rd0(input logic [8:0] a, output logic [15:0] d);
        @(negedge clk); addr0 = a;
        @(negedge clk); d = rdata0;
    endtask

    task automatic lk0(input logic [7:0] t, output logic o);
        @(negedge clk); trig0 = t;
        @(negedge clk); o = tout0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic o;
        repeat (3) @(negedge clk);
        // R1: reset state, sampled while reset is still asserted
        chk("R1 trig_out", int'(tout0), 0);
        chk("R1 rdata", int'(rdata0), 0);
        rst_n = 1'b1;
        rd0(9'h100, d); chk("R1 word0 cleared", int'(d), 0);
        for (int t = 0; t < 256; t += 17) begin
            lk0(8'(t), o); chk("R1 empty table", int'(o), 0);
        end

        // R6: count register
        rd0(9'h00F, d); chk("R6 count u0", int'(d), 8);
        @(negedge clk); addr1 = 9'h00F;
        @(negedge clk); chk("R6 count u1", int'(rdata1), 3);

        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 16; w++) begin
                if (k == 0) ref_tbl[w] = 16'hA5C3 ^ 16'(w * 16'h0101);
                else ref_tbl[w] = 16'($urandom);
                wr0(9'h100 + 9'(w), ref_tbl[w]);
            end
            // R2 and R8: registered readback
            for (int w = 0; w < 16; w++) begin
                rd0(9'h100 + 9'(w), d); chk("R2 readback", int'(d), int'(ref_tbl[w]));
            end
            // R3: exhaustive lookup
            for (int t = 0; t < 256; t++) begin
                lk0(8'(t), o);
                chk("R3 lookup", int'(o), int'(ref_tbl[t >> 4][t & 15]));
            end
            // R4: writes past the word count are dropped
            wr0(9'h110, 16'hFFFF);
            wr0(9'h1FF, 16'hFFFF);
            for (int w = 0; w < 16; w++) begin
                rd0(9'h100 + 9'(w), d); chk("R4 words intact", int'(d), int'(ref_tbl[w]));
            end
            // R5: unmapped reads return zero
            rd0(9'h110, d); chk("R5 past count", int'(d), 0);
            rd0(9'h050, d); chk("R5 unmapped", int'(d), 0);
        end

        // R7: lookup on the same edge as a write to its word
        for (int t = 3; t < 256; t += 37) begin
            logic [15:0] nw;
            nw = ref_tbl[t >> 4] ^ (16'h1 << (t & 15));
            @(negedge clk);
            trig0 = 8'(t); we0 = 1'b1; addr0 = 9'h100 + 9'(t >> 4); wd0 = nw;
            @(negedge clk);
            chk("R7 old contents", int'(tout0), int'(ref_tbl[t >> 4][t & 15]));
            we0 = 1'b0;
            @(negedge clk);
            chk("R7 new contents", int'(tout0), int'(nw[t & 15]));
            ref_tbl[t >> 4] = nw;
        end

        // R8: read data follows the address one clock later
        @(negedge clk); addr0 = 9'h100;
        @(negedge clk); addr0 = 9'h00F;
        chk("R8 prior address", int'(rdata0), int'(ref_tbl[0]));
        @(negedge clk);
        chk("R8 next address", int'(rdata0), 8);

        // R9: three inputs reach bits 0..7 of word 0 only
        @(negedge clk); we1 = 1'b1; addr1 = 9'h100; wd1 = 16'h5A3C;
        @(negedge clk); we1 = 1'b1; addr1 = 9'h101; wd1 = 16'hFFFF;
        @(negedge clk); we1 = 1'b0; addr1 = 9'h101;
        @(negedge clk); chk("R4 u1 past count", int'(rdata1), 0);
        addr1 = 9'h100;
        @(negedge clk); chk("R4 u1 word0", int'(rdata1), 16'h5A3C);
        for (int t = 0; t < 8; t++) begin
            logic [15:0] pat;
            pat = 16'h5A3C;
            @(negedge clk); trig1 = 3'(t);
            @(negedge clk); chk("R9 narrow lookup", int'(tout1), int'(pat[t]));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule